// File: doc/BRIEF.md
# Weight-Stationary MAC Grid with Faulty-Element Bypass

This block is a two-dimensional grid of multiply-accumulate elements for neural-network layer arithmetic. Before a layer runs, each element receives one signed weight. All weights of one filter or neuron go down one column, so column c computes one output channel. The weights then stay where they are. An activation vector is presented at the left edge, one lane per grid row. The block delays row r by r cycles internally, so a value meets the partial sum it belongs to in the same cycle. Activations step one element to the right per clock and partial sums step one element down. A running accumulator below each column collects the result.

A separate port writes a fault map with one bit per element, one grid row at a time. A marked element passes its incoming partial sum downward untouched, which gives the same result as a weight of zero. A filter can be taller than the grid. In that case it is computed in passes, with the weights reloaded between passes, and the column accumulators carry the running total from one pass to the next. Each vector carries a start tag and an end tag. The start tag clears the accumulator. The end tag raises a one-cycle done strobe for each column once that column's result is complete.

Top module: `ws_mac_grid`

## Requirements
- R1: While `wl_en` is high at a clock edge, grid row `wl_row` takes `wl_data`, with bits [c*8+:8] going to the element in column c. Elements in every other row keep their weights.
- R2: A weight does not change unless it is being written. The same vector under the same weights always gives the same column results.
- R3: A vector presented with `in_valid` in cycle t produces its column-c result and done strobe in cycle t+ROWS+c+1. Lane r of `in_act` (bits [r*8+:8]) enters grid row r.
- R4: An element whose fault bit is set adds nothing to the partial sum. The column result equals the result with that element's weight at zero.
- R5: A column's contribution from one vector is the sum over rows of the signed 8-bit weight times the signed 8-bit activation, sign-extended to ACCW bits. This holds for the extreme values -128 and 127.
- R6: A vector with `in_first` high starts its column accumulators from zero. A vector with `in_first` low adds onto the value left by the previous vector, which allows multi-pass filters with weights reloaded between passes.
- R7: `col_done[c]` is high for exactly one cycle for each vector with `in_last` set, and at no other time. `col_sum` holds its value while no valid vector reaches that column.
- R8: After reset, `col_done` is all zero, `col_sum` is all zero, all weights are zero and no element is marked faulty.
- R9: While `fm_en` is high at a clock edge, grid row `fm_row` takes the fault bits `fm_bits`, with bit c going to column c. A 0 written later clears the bypass for that element.
- R10: Vectors can be presented on consecutive cycles. Each one gives its own independent result in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wl_en | input | 1 | Weight row write enable |
| wl_row | input | RW | Grid row that receives the weights |
| wl_data | input | COLS*DW | One signed weight per column |
| fm_en | input | 1 | Fault map row write enable |
| fm_row | input | RW | Grid row that receives the fault bits |
| fm_bits | input | COLS | One fault bit per column (1 = bypass) |
| in_valid | input | 1 | Activation vector present |
| in_first | input | 1 | Vector starts a new accumulation |
| in_last | input | 1 | Vector finishes the accumulation |
| in_act | input | ROWS*DW | One signed activation per grid row, unskewed |
| col_sum | output | COLS*ACCW | Per-column accumulated result |
| col_done | output | COLS | Per-column one-cycle completion strobe |

## Verification
The bench builds the grid with ROWS=4, COLS=3, DW=8 and ACCW=24. With four rows, each row gets a distinct skew depth, and with three columns the first, middle and last output columns all fall on different cycles. These dimensions also keep a two-pass filter short enough to run back to back with single-pass traffic. Faults are placed in more than one row and column, so bypassed and healthy elements sit next to each other in the same column.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  // Control that travels alongside the data through the grid.
  typedef struct packed {
    logic valid;
    logic first;
    logic last;
  } wsg_tag_t;

  localparam int unsigned WSG_TAG_W = $bits(wsg_tag_t);

endpackage

// File: rtl/wsg_delay.sv
module wsg_delay #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [DEPTH];
  logic [WIDTH-1:0] stage_d [DEPTH];

  always_comb begin
    stage_d[0] = d;
    for (int i = 1; i < int'(DEPTH); i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < int'(DEPTH); i++) stage_q[i] <= stage_d[i];
    end
  end

  assign q = stage_q[DEPTH-1];

endmodule

// File: rtl/wsg_pe.sv
module wsg_pe #(
  parameter int unsigned DW   = 8,
  parameter int unsigned ACCW = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   w_we,
  input  logic signed [DW-1:0]   w_d,
  input  logic                   f_we,
  input  logic                   f_d,
  input  logic signed [DW-1:0]   act_i,
  input  logic signed [ACCW-1:0] psum_i,
  output logic signed [DW-1:0]   act_o,
  output logic signed [ACCW-1:0] psum_o
);

  localparam int unsigned PW = 2 * DW;

  logic signed [DW-1:0]   w_q, w_n;
  logic                   f_q, f_n;
  logic signed [DW-1:0]   act_q, act_n;
  logic signed [ACCW-1:0] psum_q, psum_n;
  logic signed [PW-1:0]   prod;

  always_comb begin
    w_n    = w_we ? w_d : w_q;
    f_n    = f_we ? f_d : f_q;
    prod   = w_q * act_i;
    act_n  = act_i;
    psum_n = f_q ? psum_i : psum_i + ACCW'(prod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q    <= '0;
      f_q    <= 1'b0;
      act_q  <= '0;
      psum_q <= '0;
    end else begin
      w_q    <= w_n;
      f_q    <= f_n;
      act_q  <= act_n;
      psum_q <= psum_n;
    end
  end

  assign act_o  = act_q;
  assign psum_o = psum_q;

  // R2: a weight is only replaced through its write enable
  assert_weight_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !w_we |=> $stable(w_q));

  // R4: a marked element hands the partial sum on untouched
  assert_bypass_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    f_q |=> psum_o == $past(psum_i));

endmodule

// File: rtl/wsg_colacc.sv
module wsg_colacc
  import wsg_pkg::*;
#(
  parameter int unsigned ACCW = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  wsg_tag_t               tag_i,
  input  logic signed [ACCW-1:0] sum_i,
  output logic signed [ACCW-1:0] acc_o,
  output logic                   done_o
);

  logic signed [ACCW-1:0] acc_q, acc_n;
  logic                   done_q, done_n;

  always_comb begin
    acc_n  = acc_q;
    done_n = 1'b0;
    if (tag_i.valid) begin
      acc_n  = (tag_i.first ? '0 : acc_q) + sum_i;
      done_n = tag_i.last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_n;
      done_q <= done_n;
    end
  end

  assign acc_o  = acc_q;
  assign done_o = done_q;

  // R7: the strobe follows only a closing vector
  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(tag_i.valid && tag_i.last));

  // R7: with no vector arriving the result stays put
  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_i.valid |=> $stable(acc_o));

endmodule

// File: rtl/ws_mac_grid.sv
module ws_mac_grid
  import wsg_pkg::*;
#(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 3,
  parameter int unsigned DW   = 8,
  parameter int unsigned ACCW = 24,
  localparam int unsigned RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wl_en,
  input  logic [RW-1:0]        wl_row,
  input  logic [COLS*DW-1:0]   wl_data,
  input  logic                 fm_en,
  input  logic [RW-1:0]        fm_row,
  input  logic [COLS-1:0]      fm_bits,
  input  logic                 in_valid,
  input  logic                 in_first,
  input  logic                 in_last,
  input  logic [ROWS*DW-1:0]   in_act,
  output logic [COLS*ACCW-1:0] col_sum,
  output logic [COLS-1:0]      col_done
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  logic signed [DW-1:0]   act_h  [ROWS][COLS+1];
  logic signed [ACCW-1:0] psum_v [ROWS+1][COLS];
  wsg_tag_t               tag_in;
  wsg_tag_t               tag_bot;
  wsg_tag_t               tag_c  [COLS];

  assign tag_in = '{valid: in_valid, first: in_first, last: in_last};

  // Row skew: row r is delayed r cycles before it enters column 0.
  for (genvar r = 0; r < int'(ROWS); r++) begin : g_skew
    if (r == 0) begin : g_direct
      assign act_h[r][0] = in_act[r*DW +: DW];
    end else begin : g_delay
      logic [DW-1:0] skew_q;
      wsg_delay #(.WIDTH(DW), .DEPTH(r)) u_skew (
        .clk(clk), .rst_n(rst_s_n), .d(in_act[r*DW +: DW]), .q(skew_q));
      assign act_h[r][0] = skew_q;
    end
  end

  // The tag reaches the bottom of column 0 after ROWS cycles, then one more per column.
  wsg_delay #(.WIDTH(WSG_TAG_W), .DEPTH(ROWS)) u_tag_down (
    .clk(clk), .rst_n(rst_s_n), .d(tag_in), .q(tag_bot));

  for (genvar c = 0; c < int'(COLS); c++) begin : g_tag
    if (c == 0) begin : g_first
      assign tag_c[c] = tag_bot;
    end else begin : g_step
      wsg_delay #(.WIDTH(WSG_TAG_W), .DEPTH(1)) u_tag_step (
        .clk(clk), .rst_n(rst_s_n), .d(tag_c[c-1]), .q(tag_c[c]));
    end
  end

  for (genvar c = 0; c < int'(COLS); c++) begin : g_top
    assign psum_v[0][c] = '0;
  end

  for (genvar r = 0; r < int'(ROWS); r++) begin : g_row
    logic row_w_hit, row_f_hit;
    assign row_w_hit = wl_en && (wl_row == RW'(r));
    assign row_f_hit = fm_en && (fm_row == RW'(r));
    for (genvar c = 0; c < int'(COLS); c++) begin : g_col
      wsg_pe #(.DW(DW), .ACCW(ACCW)) u_pe (
        .clk   (clk),
        .rst_n (rst_s_n),
        .w_we  (row_w_hit),
        .w_d   (wl_data[c*DW +: DW]),
        .f_we  (row_f_hit),
        .f_d   (fm_bits[c]),
        .act_i (act_h[r][c]),
        .psum_i(psum_v[r][c]),
        .act_o (act_h[r][c+1]),
        .psum_o(psum_v[r+1][c]));

      // R3: an activation advances one element to the right per clock
      assert_act_step_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
        act_h[r][c+1] == $past(act_h[r][c]));
    end
  end

  for (genvar c = 0; c < int'(COLS); c++) begin : g_acc
    logic signed [ACCW-1:0] acc_w;
    wsg_colacc #(.ACCW(ACCW)) u_acc (
      .clk   (clk),
      .rst_n (rst_s_n),
      .tag_i (tag_c[c]),
      .sum_i (psum_v[ROWS][c]),
      .acc_o (acc_w),
      .done_o(col_done[c]));
    assign col_sum[c*ACCW +: ACCW] = acc_w;
  end

endmodule

// File: tb/ws_mac_grid_bench.sv
module ws_mac_grid_bench;

  localparam int ROWS = 4;
  localparam int COLS = 3;
  localparam int DW   = 8;
  localparam int ACCW = 24;
  localparam int RW   = 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 wl_en = 1'b0;
  logic [RW-1:0]        wl_row = '0;
  logic [COLS*DW-1:0]   wl_data = '0;
  logic                 fm_en = 1'b0;
  logic [RW-1:0]        fm_row = '0;
  logic [COLS-1:0]      fm_bits = '0;
  logic                 in_valid = 1'b0;
  logic                 in_first = 1'b0;
  logic                 in_last = 1'b0;
  logic [ROWS*DW-1:0]   in_act = '0;
  logic [COLS*ACCW-1:0] col_sum;
  logic [COLS-1:0]      col_done;

  always #2 clk = ~clk;

  ws_mac_grid #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .ACCW(ACCW)) u_ws_mac_grid (
    .clk(clk), .rst_n(rst_n), .wl_en(wl_en), .wl_row(wl_row), .wl_data(wl_data),
    .fm_en(fm_en), .fm_row(fm_row), .fm_bits(fm_bits), .in_valid(in_valid),
    .in_first(in_first), .in_last(in_last), .in_act(in_act),
    .col_sum(col_sum), .col_done(col_done));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  int bw [ROWS][COLS];
  bit bf [ROWS][COLS];
  longint macc [COLS];

  logic [COLS*ACCW-1:0] exp_q [$];
  int                   exp_t [$];
  string                exp_tag [$];
  int                   rd [COLS];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic longint col_val(input int c);
    return longint'($signed(col_sum[c*ACCW +: ACCW]));
  endfunction

  // Scoreboard monitor: pops expectations per column as strobes appear.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < COLS; c++) begin
        if (col_done[c]) begin
          if (rd[c] >= exp_q.size()) begin
            chk(1'b0, "R7 unexpected done", 1, 0);
          end else begin
            longint e;
            e = longint'($signed(exp_q[rd[c]][c*ACCW +: ACCW]));
            chk(col_val(c) == e, exp_tag[rd[c]], col_val(c), e);
            chk(cyc == exp_t[rd[c]] + c, "R3 latency", cyc, exp_t[rd[c]] + c);
            rd[c]++;
          end
        end
      end
    end
  end

  // R1 driver for one weight row
  task automatic load_row(input int r, input int v [COLS]);
    wl_en  = 1'b1;
    wl_row = RW'(r);
    for (int c = 0; c < COLS; c++) begin
      wl_data[c*DW +: DW] = DW'(v[c]);
      bw[r][c] = v[c];
    end
    @(negedge clk);
    wl_en = 1'b0;
  endtask

  // R9 driver for one fault-map row
  task automatic set_faults(input int r, input logic [COLS-1:0] b);
    fm_en   = 1'b1;
    fm_row  = RW'(r);
    fm_bits = b;
    for (int c = 0; c < COLS; c++) bf[r][c] = b[c];
    @(negedge clk);
    fm_en = 1'b0;
  endtask

  // Present one vector for a cycle and push its expectation when it closes.
  task automatic send(input int a [ROWS], input bit first, input bit last, input string tag);
    logic [COLS*ACCW-1:0] pk;
    in_valid = 1'b1;
    in_first = first;
    in_last  = last;
    for (int r = 0; r < ROWS; r++) in_act[r*DW +: DW] = DW'(a[r]);
    for (int c = 0; c < COLS; c++) begin
      longint s = 0;
      for (int r = 0; r < ROWS; r++)
        if (!bf[r][c]) s += longint'(bw[r][c]) * longint'(a[r]);
      if (first) macc[c] = 0;
      macc[c] += s;
      pk[c*ACCW +: ACCW] = ACCW'(macc[c]);
    end
    if (last) begin
      exp_q.push_back(pk);
      exp_t.push_back(cyc + 1 + ROWS);
      exp_tag.push_back(tag);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain();
    repeat (ROWS + COLS + 3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin bw[r][c] = 0; bf[r][c] = 0; end
    for (int c = 0; c < COLS; c++) begin macc[c] = 0; rd[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 reset state
    chk(col_done == '0, "R8 done after reset", longint'(col_done), 0);
    chk(col_sum == '0, "R8 sum after reset", col_val(0), 0);
    // R8 weights zero: a vector before any load yields zero
    send('{5, -6, 7, 8}, 1, 1, "R8 zero weights");
    drain();

    // R1 load, R5/R10 back-to-back vectors
    load_row(0, '{1, -2, 3});
    load_row(1, '{4, 5, -6});
    load_row(2, '{-7, 8, 9});
    load_row(3, '{10, -11, 12});
    send('{1, 2, 3, 4}, 1, 1, "R5 dot");
    send('{-1, 0, 5, -3}, 1, 1, "R10 pipelined");
    send('{127, -128, 0, 1}, 1, 1, "R10 pipelined");
    drain();
    // R2 same weights, same vector: same result
    send('{1, 2, 3, 4}, 1, 1, "R2 stationary");
    drain();

    // R5 extreme operands
    for (int r = 0; r < ROWS; r++) load_row(r, '{-128, 127, -1});
    send('{-128, -128, -128, -128}, 1, 1, "R5 extremes");
    send('{127, 127, 127, 127}, 1, 1, "R5 extremes");
    send('{-128, 127, -128, 127}, 1, 1, "R5 extremes");
    drain();

    // R4/R9 faulty elements bypassed
    load_row(0, '{1, -2, 3});
    load_row(1, '{4, 5, -6});
    load_row(2, '{-7, 8, 9});
    load_row(3, '{10, -11, 12});
    set_faults(1, 3'b101);
    set_faults(3, 3'b010);
    send('{1, 2, 3, 4}, 1, 1, "R4 bypass");
    send('{9, -9, 20, -20}, 1, 1, "R4 bypass");
    drain();
    set_faults(1, 3'b000);
    send('{1, 2, 3, 4}, 1, 1, "R9 clear fault");
    drain();
    set_faults(3, 3'b000);

    // R6 multi-pass: first pass without last, reload one row, second pass closes
    send('{2, 3, -4, 5}, 1, 0, "R6 pass");
    drain();
    load_row(2, '{2, 2, 2});
    send('{6, -1, 7, 3}, 0, 1, "R6 chained pass");
    send('{1, 1, 1, 1}, 1, 1, "R6 restart");
    drain();

    // R7 strobe is gone and the value is held
    repeat (3) @(negedge clk);
    chk(col_done == '0, "R7 strobe width", longint'(col_done), 0);
    for (int c = 0; c < COLS; c++)
      chk(col_sum[c*ACCW +: ACCW] == exp_q[exp_q.size()-1][c*ACCW +: ACCW], "R7 hold",
          col_val(c), longint'($signed(exp_q[exp_q.size()-1][c*ACCW +: ACCW])));
    for (int c = 0; c < COLS; c++)
      chk(rd[c] == exp_q.size(), "R7 strobe count", rd[c], exp_q.size());

    summary();
  end

endmodule